// File: doc/BRIEF.md
# Central Chunk Queue

This block is the shared packet store at the heart of a small switch. Each input port hands it 64-bit chunks of variable-length packets. The block keeps every chunk in one common pool of fixed-size slots and links the slots into a separate queue for each output port. No output owns a private FIFO. A circular list of slot indices tracks which slots are unused. When that list is empty, writes are refused.

Each cycle at most one chunk is written and at most one chunk is read, and each of the two is picked by its own least-recently-used arbiter. The first chunk of a packet is its header: bits [7:0] give the packet length in bytes, and bits [8 +: log2(NUM_OUT)] give the destination output. The block counts the chunks from the length and flags the final chunk. An output may start draining a packet while later chunks of the same packet are still arriving, which gives cut-through operation.

Inputs use valid/ready. A chunk moves on a cycle where `in_valid[i]` and `in_ready[i]` are both high. `in_ready[i]` is only raised for an input that is valid, and the producer must hold the chunk until it is taken. Outputs are pulled: a consumer raises `out_ready[o]` when it can take a chunk that cycle. The block raises `out_valid[o]` only on a port whose ready is high, and the chunk on `out_data` is consumed in that same cycle. NUM_OUT and DEPTH must be powers of two.

Top module: `central_chunk_queue`

## Requirements
- R1: After reset the whole pool of DEPTH (128) slots is free, every output queue is empty, `out_valid` is zero, and `in_ready` is zero while no input is valid.
- R2: The number of chunks in a packet is 1 when header bits [7:0] are zero, and otherwise ceil(length/8). A 255-byte packet therefore takes 32 chunks. `out_last` is high exactly when the chunk being delivered is the final chunk of its packet.
- R3: Each output delivers the chunks routed to it in the order they were accepted, with data unchanged.
- R4: At most one bit of `in_ready` is high per cycle. No chunk is accepted while the free pool is empty, so a full pool accepts exactly 128 chunks.
- R5: Write grant goes to the eligible input that is ranked least recently used. The ranking changes only when the final chunk of a packet is accepted, and that input then becomes most recently used. After reset the rank is input 0 first, then 1, 2, 3.
- R6: At most one bit of `out_valid` is high per cycle, and only for an output whose queue is non-empty and whose `out_ready` is high. Among such outputs the least recently used wins. The ranking changes only when a final chunk is read. After reset the rank is output 0 first.
- R7: A chunk accepted in cycle t can be delivered on its output in cycle t+1, even while the rest of its packet has not arrived.
- R8: A slot is returned to the pool when its chunk is delivered and can be reused from the next cycle on, but not in the same cycle.
- R9: While one input is mid-packet to an output, a header from another input for that same output is held off. It becomes eligible in the cycle after the first packet's final chunk is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN | Per-input chunk valid |
| in_ready | output | NUM_IN | Per-input chunk accepted this cycle |
| in_data | input | NUM_IN*DATA_W | Chunk words, input i at bits [i*DATA_W +: DATA_W] |
| out_ready | input | NUM_OUT | Per-output consumer can take a chunk this cycle |
| out_valid | output | NUM_OUT | One-hot0: the output delivering a chunk this cycle |
| out_data | output | DATA_W | Delivered chunk |
| out_last | output | 1 | Delivered chunk ends its packet |

## Verification
Directed patterns cover the following:
- A single three-chunk packet shows the cut-through timing.
- Two inputs aiming at the same output separate a correct per-output lock from interleaved packets.
- Four inputs, each with two one-chunk packets, and then four outputs draining together expose the exact least-recently-used order on both sides.
- Filling the pool with outputs stalled and then freeing a single slot distinguishes the correct capacity and next-cycle slot reuse from an off-by-one or a same-cycle bypass.

Long random traffic then mixes packet lengths (0, short, 255 and anything else) and per-output stall rates. A behavioural model follows it every cycle, which catches ordering, last-flag or arbitration slips that only show up under overlapping packets.

// File: rtl/ccq_pkg.sv
package ccq_pkg;
  localparam int unsigned LEN_LSB  = 0;
  localparam int unsigned LEN_W    = 8;
  localparam int unsigned DEST_LSB = 8;
  localparam int unsigned CHUNK_CNT_W = 6;

  // number of 8-byte chunks needed for a packet of nbytes (zero counts as one)
  function automatic logic [CHUNK_CNT_W-1:0] chunks_of(input logic [LEN_W-1:0] nbytes);
    logic [LEN_W:0] padded;
    padded = {1'b0, nbytes} + 9'd7;
    if (nbytes == '0) return 6'd1;
    return padded[LEN_W:3];
  endfunction
endpackage

// File: rtl/ccq_lru_arb.sv
module ccq_lru_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] gnt
);
  // ahead[i][j] set: i ranks before j
  logic [N-1:0] ahead [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && ahead[j][i]) gnt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          ahead[i][j] <= (i < j);
    end else if (upd) begin
      for (int g = 0; g < N; g++) begin
        if (gnt[g]) begin
          for (int j = 0; j < N; j++) begin
            if (j != g) begin
              ahead[g][j] <= 1'b0;
              ahead[j][g] <= 1'b1;
            end
          end
        end
      end
    end
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)) else $error("grant not one-hot"); // R5
  AST_ARB_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0) else $error("grant without request"); // R5
  AST_ARB_WORK: assert property (@(posedge clk) disable iff (!rst_n) (req != '0) |-> (gnt != '0)) else $error("idle with requests"); // R5

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = i + 1; j < N; j++) begin : g_col
      AST_ARB_ORDER: assert property (@(posedge clk) disable iff (!rst_n) ahead[i][j] != ahead[j][i]) else $error("rank not total"); // R5
    end
  end
endmodule

// File: rtl/ccq_pkt_track.sv
module ccq_pkt_track #(
  parameter int OW = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ccq_pkg::LEN_W-1:0]        hdr_len,
  input  logic [OW-1:0]                    hdr_dest,
  input  logic                             take,
  output logic                             first,
  output logic                             last,
  output logic [OW-1:0]                    dest
);
  import ccq_pkg::*;

  logic                   busy;
  logic [CHUNK_CNT_W-1:0] rem;
  logic [OW-1:0]          dst_q;
  logic [CHUNK_CNT_W-1:0] hdr_chunks;

  always_comb begin
    hdr_chunks = chunks_of(hdr_len);
    first = !busy;
    dest  = busy ? dst_q : hdr_dest;
    last  = busy ? (rem == 6'd1) : (hdr_chunks == 6'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rem   <= '0;
      dst_q <= '0;
    end else if (take) begin
      if (!busy) begin
        if (hdr_chunks != 6'd1) begin
          busy  <= 1'b1;
          rem   <= hdr_chunks - 6'd1;
          dst_q <= hdr_dest;
        end
      end else begin
        rem <= rem - 6'd1;
        if (rem == 6'd1) busy <= 1'b0;
      end
    end
  end

  AST_TRK_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (rem != '0 && rem < 6'd32)) else $error("chunk count out of range"); // R2
endmodule

// File: rtl/ccq_free_ring.sv
module ccq_free_ring #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [AW-1:0] pop_idx,
  input  logic          push,
  input  logic [AW-1:0] push_idx,
  output logic          avail,
  output logic [CW-1:0] free_cnt
);
  logic [AW-1:0] ring [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  assign pop_idx = ring[rd_ptr];
  assign avail   = (free_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ring[k] <= AW'(k);
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      free_cnt <= CW'(DEPTH);
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (push) begin
        ring[wr_ptr] <= push_idx;
        wr_ptr       <= wr_ptr + 1'b1;
      end
      free_cnt <= free_cnt + CW'(push) - CW'(pop);
    end
  end

  AST_POOL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> free_cnt != '0) else $error("slot taken from empty pool"); // R4
  AST_POOL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> free_cnt != CW'(DEPTH)) else $error("slot returned to full pool"); // R8
endmodule

// File: rtl/ccq_list_store.sv
module ccq_list_store #(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 128,
  parameter int DATA_W  = 64,
  localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [OW-1:0]      wr_port,
  input  logic [AW-1:0]      wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_last,
  input  logic               rd_en,
  input  logic [OW-1:0]      rd_port,
  output logic [AW-1:0]      rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_last,
  output logic [NUM_OUT-1:0] nonempty,
  output logic [CW-1:0]      used
);
  logic [DATA_W-1:0] data_ram [DEPTH];
  logic              last_ram [DEPTH];
  logic [AW-1:0]     nxt_ram  [DEPTH];
  logic [AW-1:0]     head [NUM_OUT];
  logic [AW-1:0]     tail [NUM_OUT];
  logic [CW-1:0]     cnt  [NUM_OUT];

  assign rd_idx  = head[rd_port];
  assign rd_data = data_ram[rd_idx];
  assign rd_last = last_ram[rd_idx];

  always_comb begin
    used = '0;
    for (int p = 0; p < NUM_OUT; p++) begin
      nonempty[p] = (cnt[p] != '0);
      used        = used + cnt[p];
    end
  end

  // slot contents and links
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_ram[wr_idx] <= wr_data;
      last_ram[wr_idx] <= wr_last;
      if (cnt[wr_port] != '0) nxt_ram[tail[wr_port]] <= wr_idx;
    end
  end

  // per-output list pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_OUT; p++) begin
        head[p] <= '0;
        tail[p] <= '0;
        cnt[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_OUT; p++) begin
        logic w_here, r_here;
        w_here = wr_en && (wr_port == OW'(p));
        r_here = rd_en && (rd_port == OW'(p));
        if (w_here && (cnt[p] == '0 || (cnt[p] == CW'(1) && r_here)))
          head[p] <= wr_idx;
        else if (r_here)
          head[p] <= nxt_ram[head[p]];
        if (w_here) tail[p] <= wr_idx;
        cnt[p] <= cnt[p] + CW'(w_here) - CW'(r_here);
      end
    end
  end

  AST_LIST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> nonempty[rd_port]) else $error("read from empty list"); // R3
  AST_LIST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> used != CW'(DEPTH)) else $error("list push beyond pool"); // R8

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_vis
    AST_LIST_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_port == OW'(p)) |=> nonempty[p]) else $error("written chunk not visible"); // R7
  end
endmodule

// File: rtl/central_chunk_queue.sv
module central_chunk_queue #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 128,
  parameter int DATA_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IN-1:0]          in_valid,
  output logic [NUM_IN-1:0]          in_ready,
  input  logic [NUM_IN*DATA_W-1:0]   in_data,
  input  logic [NUM_OUT-1:0]         out_ready,
  output logic [NUM_OUT-1:0]         out_valid,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_last
);
  import ccq_pkg::*;

  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  // per-input packet tracking
  logic          trk_first [NUM_IN];
  logic          trk_last  [NUM_IN];
  logic [OW-1:0] trk_dest  [NUM_IN];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_trk
    ccq_pkt_track #(.OW(OW)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .hdr_len  (in_data[i*DATA_W + LEN_LSB +: LEN_W]),
      .hdr_dest (in_data[i*DATA_W + DEST_LSB +: OW]),
      .take     (in_ready[i]),
      .first    (trk_first[i]),
      .last     (trk_last[i]),
      .dest     (trk_dest[i])
    );
  end

  // per-output write locks
  logic [NUM_OUT-1:0] olock;
  logic [IW-1:0]      oown [NUM_OUT];

  logic               pool_avail;
  logic [AW-1:0]      pool_idx;
  logic [CW-1:0]      pool_cnt;
  logic [CW-1:0]      list_used;

  // write side
  logic [NUM_IN-1:0]  wr_req;
  logic               wr_fire, wr_last, wr_first;
  logic [IW-1:0]      wsel;
  logic [OW-1:0]      wr_dest;
  logic [DATA_W-1:0]  wr_data;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++)
      wr_req[i] = in_valid[i] && pool_avail && (!trk_first[i] || !olock[trk_dest[i]]);
  end

  ccq_lru_arb #(.N(NUM_IN)) u_wr_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (wr_req),
    .upd   (wr_fire && wr_last),
    .gnt   (in_ready)
  );

  always_comb begin
    wsel = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (in_ready[i]) wsel = IW'(i);
    wr_fire  = |in_ready;
    wr_dest  = trk_dest[wsel];
    wr_last  = trk_last[wsel];
    wr_first = trk_first[wsel];
    wr_data  = in_data[wsel*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      olock <= '0;
      for (int o = 0; o < NUM_OUT; o++) oown[o] <= '0;
    end else if (wr_fire) begin
      if (wr_first && !wr_last) begin
        olock[wr_dest] <= 1'b1;
        oown[wr_dest]  <= wsel;
      end else if (!wr_first && wr_last) begin
        olock[wr_dest] <= 1'b0;
      end
    end
  end

  // read side
  logic [NUM_OUT-1:0] nonempty;
  logic               rd_fire, rd_last;
  logic [OW-1:0]      rsel;
  logic [AW-1:0]      rd_idx;
  logic [DATA_W-1:0]  rd_data;

  ccq_lru_arb #(.N(NUM_OUT)) u_rd_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (nonempty & out_ready),
    .upd   (rd_fire && rd_last),
    .gnt   (out_valid)
  );

  always_comb begin
    rsel = '0;
    for (int o = 0; o < NUM_OUT; o++)
      if (out_valid[o]) rsel = OW'(o);
    rd_fire  = |out_valid;
    out_data = rd_data;
    out_last = rd_fire && rd_last;
  end

  ccq_free_ring #(.DEPTH(DEPTH)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (wr_fire),
    .pop_idx  (pool_idx),
    .push     (rd_fire),
    .push_idx (rd_idx),
    .avail    (pool_avail),
    .free_cnt (pool_cnt)
  );

  ccq_list_store #(.NUM_OUT(NUM_OUT), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_lists (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_port  (wr_dest),
    .wr_idx   (pool_idx),
    .wr_data  (wr_data),
    .wr_last  (wr_last),
    .rd_en    (rd_fire),
    .rd_port  (rsel),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .nonempty (nonempty),
    .used     (list_used)
  );

  AST_POOL_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n) ((CW+1)'(pool_cnt) + (CW+1)'(list_used)) == (CW+1)'(DEPTH)) else $error("slots lost or duplicated"); // R8
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !pool_avail |-> in_ready == '0) else $error("write with empty pool"); // R4
  AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid & ~out_ready) == '0) else $error("delivery to stalled output"); // R6
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid != '0) else $error("last flag without delivery"); // R2
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> out_valid == '0) else $error("delivery right after reset"); // R1

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_lock_chk
    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) (olock[o] && wr_fire && wr_dest == OW'(o)) |-> wsel == oown[o]) else $error("locked output written by other input"); // R9
  end
endmodule

// File: tb/central_chunk_queue_tb.sv
module central_chunk_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int W  = 64;
  localparam int MAX_CYCLES = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NI-1:0]   in_valid = '0;
  logic [NI-1:0]   in_ready;
  logic [NI*W-1:0] in_data = '0;
  logic [NO-1:0]   out_ready = '0;
  logic [NO-1:0]   out_valid;
  logic [W-1:0]    out_data;
  logic            out_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  central_chunk_queue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int         order_w[$], order_r[$];
  logic [W-1:0] q_data [NO][$];
  bit         q_last [NO][$];
  int         free_m;
  bit         lock_m [NO];
  bit         busy_m [NI];
  int         rem_m  [NI];
  int         dst_m  [NI];

  // stimulus state
  logic [W-1:0] pkt_q [NI][$];
  int  vprob = 100;
  int  oprob [NO];
  bit  gen_en = 0;
  logic [NI-1:0] obs_in_ready;
  logic [NO-1:0] obs_out_valid;
  logic [W-1:0]  obs_out_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nchunks(input int len);
    return (len == 0) ? 1 : (len + 7) / 8;
  endfunction

  task automatic add_packet(input int i, input int dest, input int len);
    logic [W-1:0] h;
    h = {$urandom(), $urandom()};
    h[15:0] = {8'(dest), 8'(len)};
    pkt_q[i].push_back(h);
    for (int k = 1; k < nchunks(len); k++) pkt_q[i].push_back({$urandom(), $urandom()});
  endtask

  task automatic to_back(ref int ord[$], input int id);
    for (int k = 0; k < ord.size(); k++)
      if (ord[k] == id) begin ord.delete(k); break; end
    ord.push_back(id);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0;
    out_ready = '0;
    for (int i = 0; i < NI; i++) pkt_q[i].delete();
    order_w = {};
    order_r = {};
    for (int i = 0; i < NI; i++) begin order_w.push_back(i); busy_m[i] = 0; rem_m[i] = 0; dst_m[i] = 0; end
    for (int o = 0; o < NO; o++) begin order_r.push_back(o); q_data[o].delete(); q_last[o].delete(); lock_m[o] = 0; end
    free_m = 128;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic bit model_empty();
    for (int o = 0; o < NO; o++) if (q_data[o].size() != 0) return 0;
    for (int i = 0; i < NI; i++) if (pkt_q[i].size() != 0) return 0;
    return 1;
  endfunction

  // one cycle: drive after the edge, compare and advance the model at the falling edge
  task automatic step();
    bit elig [NI]; bit lst [NI]; int dst [NI];
    int wg, rg;
    logic [NI-1:0] exp_ir;
    logic [NO-1:0] exp_ov;
    for (int i = 0; i < NI; i++) begin
      in_valid[i] = (pkt_q[i].size() > 0) && ($urandom_range(99) < vprob);
      in_data[i*W +: W] = (pkt_q[i].size() > 0) ? pkt_q[i][0] : '0;
    end
    for (int o = 0; o < NO; o++) out_ready[o] = ($urandom_range(99) < oprob[o]);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      logic [W-1:0] w;
      w = in_data[i*W +: W];
      dst[i] = busy_m[i] ? dst_m[i] : int'(w[15:8]);
      lst[i] = busy_m[i] ? (rem_m[i] == 1) : (nchunks(int'(w[7:0])) == 1);
      elig[i] = in_valid[i] && (free_m > 0) && (busy_m[i] || !lock_m[dst[i]]);
    end
    wg = -1;
    foreach (order_w[k]) if (wg < 0 && elig[order_w[k]]) wg = order_w[k];
    rg = -1;
    foreach (order_r[k]) if (rg < 0 && out_ready[order_r[k]] && q_data[order_r[k]].size() > 0) rg = order_r[k];
    exp_ir = (wg >= 0) ? NI'(1 << wg) : '0;
    exp_ov = (rg >= 0) ? NO'(1 << rg) : '0;
    chk(in_ready === exp_ir, "R5", "write grant", W'(in_ready), W'(exp_ir));
    chk(out_valid === exp_ov, "R6", "read grant", W'(out_valid), W'(exp_ov));
    if (rg >= 0) begin
      chk(out_data === q_data[rg][0], "R3", "delivered data", out_data, q_data[rg][0]);
      chk(out_last === q_last[rg][0], "R2", "last flag", W'(out_last), W'(q_last[rg][0]));
    end else begin
      chk(out_last === 1'b0, "R2", "last flag idle", W'(out_last), '0);
    end
    obs_in_ready = in_ready;
    obs_out_valid = out_valid;
    obs_out_data = out_data;
    if (rg >= 0) begin
      bit l;
      void'(q_data[rg].pop_front());
      l = q_last[rg].pop_front();
      free_m++;
      if (l) to_back(order_r, rg);
    end
    if (wg >= 0) begin
      logic [W-1:0] w;
      w = pkt_q[wg].pop_front();
      q_data[dst[wg]].push_back(w);
      q_last[dst[wg]].push_back(lst[wg]);
      free_m--;
      if (!busy_m[wg]) begin
        if (!lst[wg]) begin
          busy_m[wg] = 1; rem_m[wg] = nchunks(int'(w[7:0])) - 1; dst_m[wg] = dst[wg]; lock_m[dst[wg]] = 1;
        end
      end else begin
        rem_m[wg]--;
        if (lst[wg]) begin busy_m[wg] = 0; lock_m[dst[wg]] = 0; end
      end
      if (lst[wg]) to_back(order_w, wg);
    end
    if (gen_en)
      for (int i = 0; i < NI; i++)
        if (pkt_q[i].size() == 0) begin
          int sel, len;
          sel = $urandom_range(3);
          len = (sel == 0) ? $urandom_range(8) : (sel == 1) ? 255 : $urandom_range(255);
          add_packet(i, $urandom_range(NO-1), len);
        end
    @(posedge clk);
    #1;
  endtask

  task automatic set_oprob(input int p);
    for (int o = 0; o < NO; o++) oprob[o] = p;
  endtask

  task automatic drain(input int max_steps);
    set_oprob(100);
    vprob = 100;
    for (int k = 0; k < max_steps && !model_empty(); k++) step();
  endtask

  initial begin
    logic [W-1:0] hdr;
    int acc;
    set_oprob(0);
    // reset state
    do_reset();
    step();
    chk(obs_in_ready == '0, "R1", "ready after reset", W'(obs_in_ready), '0);
    chk(obs_out_valid == '0, "R1", "valid after reset", W'(obs_out_valid), '0);

    // cut-through: 3-chunk packet, first chunk seen one cycle after acceptance
    add_packet(0, 2, 24);
    hdr = pkt_q[0][0];
    oprob[2] = 100;
    step();
    chk(obs_in_ready == 4'b0001, "R7", "header accepted", W'(obs_in_ready), 64'h1);
    step();
    chk(obs_out_valid == 4'b0100, "R7", "header delivered next cycle", W'(obs_out_valid), 64'h4);
    chk(obs_out_data == hdr, "R7", "header word", obs_out_data, hdr);
    drain(20);

    // per-output lock between two inputs
    set_oprob(0);
    add_packet(0, 1, 32);
    step();
    add_packet(1, 1, 8);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(obs_in_ready[1] == 1'b0, "R9", "second header held", W'(obs_in_ready), 64'h1);
    end
    step();
    chk(obs_in_ready == 4'b0010, "R9", "second header after lock release", W'(obs_in_ready), 64'h2);
    drain(40);

    // LRU order on both sides
    do_reset();
    set_oprob(0);
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NI; i++) add_packet(i, i, 8);
    for (int k = 0; k < 8; k++) begin
      step();
      chk(obs_in_ready == NI'(1 << (k % 4)), "R5", "write rotation", W'(obs_in_ready), W'(1 << (k % 4)));
    end
    set_oprob(100);
    for (int k = 0; k < 8; k++) begin
      step();
      chk(obs_out_valid == NO'(1 << (k % 4)), "R6", "read rotation", W'(obs_out_valid), W'(1 << (k % 4)));
    end

    // fill the pool, then free one slot
    do_reset();
    set_oprob(0);
    for (int p = 0; p < 5; p++) add_packet(0, p % 4, 255);
    acc = 0;
    for (int k = 0; k < 140; k++) begin
      step();
      if (obs_in_ready[0]) acc++;
    end
    chk(acc == 128, "R4", "chunks accepted into full pool", W'(acc), 64'd128);
    chk(obs_in_ready == '0, "R4", "no accept when pool empty", W'(obs_in_ready), '0);
    oprob[0] = 100;
    step();
    chk(obs_out_valid == 4'b0001, "R8", "one chunk delivered", W'(obs_out_valid), 64'h1);
    chk(obs_in_ready == '0, "R8", "no same-cycle reuse", W'(obs_in_ready), '0);
    oprob[0] = 0;
    step();
    chk(obs_in_ready == 4'b0001, "R8", "freed slot reused next cycle", W'(obs_in_ready), 64'h1);
    step();
    chk(obs_in_ready == '0, "R4", "pool empty again", W'(obs_in_ready), '0);
    drain(400);
    chk(model_empty(), "R3", "fill traffic delivered", '0, '0);

    // random traffic with mixed lengths and stall rates
    do_reset();
    gen_en = 1;
    vprob = 70;
    for (int phase = 0; phase < 4; phase++) begin
      for (int o = 0; o < NO; o++) oprob[o] = (phase == 0) ? 60 : $urandom_range(15, 95);
      for (int k = 0; k < 1000; k++) step();
    end
    gen_en = 0;
    drain(4000);
    chk(model_empty(), "R3", "random traffic fully delivered", '0, '0);
    step();
    chk(obs_out_valid == '0, "R6", "idle after drain", W'(obs_out_valid), '0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=done", MAX_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule